// File: doc/BRIEF.md
# Serial Port FIFO and Interrupt Status Unit

This unit sits between a register read/write port and the shift engine of a clocked serial interface. It holds one transmit and one receive queue, each sized in bytes. Each queue carries either 8-bit or 16-bit entries, depending on a width bit in the mode register. Software fills the transmit queue through a data window and drains the receive queue through a second window. The shift engine pulls transmit words and pushes received words through single-cycle strobes.

Both queues report their occupancy in bytes. A write to either level register empties that queue. A status register collects event flags: receive threshold reached, transmit half-drained, transfer end, transmit end, overflow and underrun. Software clears a flag by writing 1 to it. A control register holds the enable bit for each flag, and the single interrupt output is raised while any enabled flag is set.

Top module: `sio_fifo_irq`

Register offsets (reg_addr): mode 0x00, control 0x08, status 0x0C, receive level 0x10, transmit level 0x14, receive window 0x18, transmit window 0x1C, trigger 0x20. Mode bits: 6 selects send-receive (0 is receive-only), 5 selects 16-bit entries. Flag positions in status, with the enable at the same position in control: receive trigger 0, transmit trigger 4, transfer end 8, transmit end 9, overflow 12, underrun 13. Control bit 19 enables the receive threshold compare. Trigger register bits [2:0] hold the threshold code.

## Requirements
- R1: After reset, both level registers read 0, the status register reads 0 and irq is low.
- R2: Both queues are first-in first-out. In 8-bit mode only bits [7:0] of a written or received word are kept, and the upper bits read as 0. In 16-bit mode bits [15:0] are kept.
- R3: A queue holds 32 entries in 8-bit mode and 16 in 16-bit mode. A push into a full transmit queue is dropped and leaves the level unchanged.
- R4: The level registers count bytes, so each 16-bit entry counts as 2.
- R5: Any write to a level register empties that queue, and the level then reads 0.
- R6: With control bit 19 set, status bit 0 rises once the receive occupancy reaches 2^code entries (code 0 to 4 gives 1 to 16; code 5 or above gives 32). With bit 19 clear, bit 0 stays low.
- R7: Status bit 9 rises when a transmit pop leaves the transmit queue empty.
- R8: A receive push while the receive queue is full sets status bit 12, and the word is dropped.
- R9: A transmit pop on an empty queue sets status bit 13 in send-receive mode (mode bit 6 = 1) and has no effect in receive-only mode.
- R10: Writing 1 to a status bit clears it, writing 0 leaves it, and a new event in the same cycle wins over the clear.
- R11: irq is high exactly while some status bit is set together with the control bit at the same position.
- R12: A read of the receive window while the queue is empty returns 0 and leaves the level at 0.
- R13: A xfer_done pulse sets status bit 8. Status bit 4 rises when a transmit pop leaves 16 bytes or fewer in the transmit queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive window) |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| tx_pop | input | 1 | Shift engine takes the head transmit entry |
| tx_word | output | 16 | Head of the transmit queue |
| tx_ready | output | 1 | Transmit queue is not empty |
| rx_push | input | 1 | Shift engine delivers a received word |
| rx_word | input | 16 | Received word |
| xfer_done | input | 1 | Shift engine finished a transfer |
| irq | output | 1 | Interrupt request |

## Verification
The ordering check uses short mixed byte patterns with upper bits set, so it separates correct masking from plain pass-through. Filling past capacity in both widths tells an entry count apart from a byte count, and so does the 16-bit level check. The threshold is tried with the enable off and on, one entry below and exactly at the threshold, which pins both the power-of-two decoding and the gating. The pop-on-empty test runs in both modes to show that underrun depends on send-receive mode.

// File: rtl/sio_pkg.sv
// Shared register offsets and bit positions for the serial FIFO unit.
// Assumes a byte-addressed register port with 32-bit registers.
package sio_pkg;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_MODE  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_RXLVL = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_TXLVL = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_RXWIN = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_TXWIN = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_TRIG  = 6'h20;

    localparam int B_RXTRG  = 0;
    localparam int B_TXTRG  = 4;
    localparam int B_XEND   = 8;
    localparam int B_TXEND  = 9;
    localparam int B_OVER   = 12;
    localparam int B_UNDER  = 13;
    localparam int B_TRGEN  = 19;
    localparam int B_WIDE   = 5;
    localparam int B_SNDRCV = 6;

    localparam logic [31:0] FLAG_MASK = (32'd1 << B_RXTRG) | (32'd1 << B_TXTRG) |
                                        (32'd1 << B_XEND)  | (32'd1 << B_TXEND) |
                                        (32'd1 << B_OVER)  | (32'd1 << B_UNDER);
    localparam logic [31:0] CTRL_MASK = FLAG_MASK | (32'd1 << B_TRGEN);
    localparam logic [31:0] MODE_MASK = (32'd1 << B_WIDE) | (32'd1 << B_SNDRCV);
endpackage

// File: rtl/sio_fifo.sv
// Circular queue with a run-time capacity limit.
// Assumes DEPTH is a power of two and cap <= DEPTH. Pushes when full and
// pops when empty are ignored; flush wins over both.
module sio_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [CW-1:0] cap,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count >= cap);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // Entry storage write.
    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= wdata;
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R3
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (count == $past(count)));
    // R5
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));
endmodule

// File: rtl/sio_flags.sv
// Sticky event flags with write-one-to-clear and an enable-gated interrupt.
// Assumes set and clr are single-cycle vectors; set wins over clr.
module sio_flags #(
    parameter int          NB   = 32,
    parameter logic [31:0] KEEP = sio_pkg::FLAG_MASK
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] set,
    input  logic [NB-1:0] clr,
    input  logic [NB-1:0] en,
    output logic [NB-1:0] stat,
    output logic          irq
);
    // Flag register update.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= ((stat & ~clr) | set) & KEEP[NB-1:0];
    end

    assign irq = |(stat & en);

    // R10
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr) |=> ((stat & $past(clr) & ~$past(set)) == '0));
    // R11
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set & KEEP[NB-1:0] & en)) && $stable(en) |=> irq);
endmodule

// File: rtl/sio_fifo_irq.sv
// Transmit/receive queues and interrupt status for a clocked serial port.
// Assumes the shift engine strobes tx_pop/rx_push for one cycle per word and
// that software flushes both queues before changing the entry width.
module sio_fifo_irq #(
    parameter int FIFO_BYTES = 32,
    parameter int WORD_W     = 16,
    localparam int ENT       = FIFO_BYTES,
    localparam int CW        = $clog2(ENT + 1),
    localparam int MAXTRG    = $clog2(ENT),
    localparam int HALF      = FIFO_BYTES / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [5:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              tx_pop,
    output logic [WORD_W-1:0] tx_word,
    output logic              tx_ready,
    input  logic              rx_push,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              xfer_done,
    output logic              irq
);
    import sio_pkg::*;

    logic [31:0]       mode_r, ctrl_r, stat;
    logic [2:0]        trg_r;
    logic              wide;
    logic [CW-1:0]     cap, thr;
    logic [CW-1:0]     tx_cnt, rx_cnt;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [WORD_W-1:0] rx_head, tx_in, rx_in;
    logic [31:0]       set_v, clr_v;
    logic [CW:0]       tx_bytes, rx_bytes, tx_after;

    function automatic logic [CW:0] to_bytes(input logic [CW-1:0] n, input logic w);
        return w ? {n, 1'b0} : {1'b0, n};
    endfunction

    function automatic logic [WORD_W-1:0] fit(input logic [WORD_W-1:0] d, input logic w);
        return w ? d : (d & WORD_W'(8'hFF));
    endfunction

    assign wide = mode_r[B_WIDE];
    assign cap  = wide ? CW'(ENT / 2) : CW'(ENT);
    assign thr  = (trg_r >= 3'(MAXTRG)) ? CW'(ENT) : (CW'(1) << trg_r);

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_r <= '0;
            ctrl_r <= '0;
            trg_r  <= '0;
        end else if (reg_wr) begin
            if (reg_addr == OFS_MODE) mode_r <= reg_wdata & MODE_MASK;
            if (reg_addr == OFS_CTRL) ctrl_r <= reg_wdata & CTRL_MASK;
            if (reg_addr == OFS_TRIG) trg_r  <= reg_wdata[2:0];
        end
    end

    assign tx_in = fit(reg_wdata[WORD_W-1:0], wide);
    assign rx_in = fit(rx_word, wide);

    sio_fifo #(.DEPTH(ENT), .W(WORD_W)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .flush(reg_wr && reg_addr == OFS_TXLVL),
        .push(reg_wr && reg_addr == OFS_TXWIN),
        .pop(tx_pop), .cap(cap), .wdata(tx_in),
        .rdata(tx_word), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    sio_fifo #(.DEPTH(ENT), .W(WORD_W)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .flush(reg_wr && reg_addr == OFS_RXLVL),
        .push(rx_push),
        .pop(reg_rd && reg_addr == OFS_RXWIN), .cap(cap), .wdata(rx_in),
        .rdata(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    assign tx_ready = !tx_empty;
    assign tx_bytes = to_bytes(tx_cnt, wide);
    assign rx_bytes = to_bytes(rx_cnt, wide);
    assign tx_after = to_bytes(tx_cnt - CW'(1), wide);

    // Event detection feeding the flag register.
    always_comb begin
        set_v          = '0;
        set_v[B_RXTRG] = ctrl_r[B_TRGEN] && (rx_cnt >= thr);
        set_v[B_TXTRG] = tx_pop && !tx_empty && (tx_after <= (CW+1)'(HALF));
        set_v[B_XEND]  = xfer_done;
        set_v[B_TXEND] = tx_pop && (tx_cnt == CW'(1));
        set_v[B_OVER]  = rx_push && rx_full;
        set_v[B_UNDER] = tx_pop && tx_empty && mode_r[B_SNDRCV];
    end

    assign clr_v = (reg_wr && reg_addr == OFS_STAT) ? reg_wdata : '0;

    sio_flags #(.NB(32), .KEEP(FLAG_MASK)) u_flags (
        .clk(clk), .rst_n(rst_n), .set(set_v), .clr(clr_v),
        .en(ctrl_r & FLAG_MASK), .stat(stat), .irq(irq)
    );

    // Register read multiplexer.
    always_comb begin
        case (reg_addr)
            OFS_MODE:  reg_rdata = mode_r;
            OFS_CTRL:  reg_rdata = ctrl_r;
            OFS_STAT:  reg_rdata = stat;
            OFS_RXLVL: reg_rdata = 32'(rx_bytes);
            OFS_TXLVL: reg_rdata = 32'(tx_bytes);
            OFS_RXWIN: reg_rdata = rx_empty ? 32'd0 : 32'(rx_head);
            OFS_TRIG:  reg_rdata = {29'd0, trg_r};
            default:   reg_rdata = 32'd0;
        endcase
    end

    // R9
    underrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && !tx_ready && mode_r[B_SNDRCV]) |=> stat[B_UNDER]);
    // R8
    overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_cnt == cap) |=> stat[B_OVER]);
    // R7
    txend_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && tx_cnt == CW'(1) && !(reg_wr && reg_addr == OFS_TXWIN)) |=> !tx_ready);
endmodule

// File: tb/sio_fifo_irq_test.sv
module sio_fifo_irq_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [5:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        tx_pop = 0, tx_ready;
    logic [15:0] tx_word;
    logic        rx_push = 0;
    logic [15:0] rx_word = 0;
    logic        xfer_done = 0;
    logic        irq;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    localparam logic [5:0] A_MODE = 6'h00, A_CTRL = 6'h08, A_STAT = 6'h0C,
        A_RXL = 6'h10, A_TXL = 6'h14, A_RXW = 6'h18, A_TXW = 6'h1C, A_TRG = 6'h20;

    sio_fifo_irq uut (.*);

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic pop_tx();
        @(negedge clk); tx_pop = 1;
        @(negedge clk); tx_pop = 0;
    endtask

    task automatic push_rx(input logic [15:0] w);
        @(negedge clk); rx_push = 1; rx_word = w;
        @(negedge clk); rx_push = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_RXL, v); chk("R1 rx level", v, 0);
        rd(A_TXL, v); chk("R1 tx level", v, 0);
        rd(A_STAT, v); chk("R1 status", v, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_tx_order();
        logic [31:0] v;
        wr(A_MODE, 32'h40);
        wr(A_TXW, 32'h1A5); wr(A_TXW, 32'h3C); wr(A_TXW, 32'hF7F);
        rd(A_TXL, v); chk("R4 tx level narrow", v, 3);
        @(negedge clk); chk("R2 head masked", tx_word, 16'hA5);
        pop_tx(); chk("R2 second", tx_word, 16'h3C);
        pop_tx(); chk("R2 third", tx_word, 16'h7F);
        rd(A_STAT, v); chk("R7 no end yet", v[9], 0);
        pop_tx(); chk("R7 ready low", tx_ready, 0);
        rd(A_STAT, v); chk("R7 tx end and R13 half", v, 32'h210);
        wr(A_STAT, 32'h010);
        rd(A_STAT, v); chk("R10 partial clear", v, 32'h200);
        wr(A_STAT, 32'h200);
        rd(A_STAT, v); chk("R10 cleared", v, 0);
    endtask

    task automatic t_underrun();
        logic [31:0] v;
        wr(A_MODE, 32'h40); pop_tx();
        rd(A_STAT, v); chk("R9 underrun send-receive", v, 32'h2000);
        wr(A_STAT, 32'hFFFF_FFFF);
        wr(A_MODE, 32'h00); pop_tx();
        rd(A_STAT, v); chk("R9 none in receive-only", v, 0);
    endtask

    task automatic t_capacity();
        logic [31:0] v;
        wr(A_MODE, 32'h40);
        for (int i = 0; i < 34; i++) wr(A_TXW, i);
        rd(A_TXL, v); chk("R3 narrow cap", v, 32);
        wr(A_TXL, 0);
        rd(A_TXL, v); chk("R5 tx flush", v, 0);
        wr(A_MODE, 32'h60);
        for (int i = 0; i < 18; i++) wr(A_TXW, 32'hBE00 + i);
        rd(A_TXL, v); chk("R3 wide cap in bytes", v, 32);
        @(negedge clk); chk("R2 wide head", tx_word, 16'hBE00);
        wr(A_TXL, 0);
        wr(A_TXW, 32'h1BEEF); wr(A_TXW, 1); wr(A_TXW, 2);
        rd(A_TXL, v); chk("R4 wide level", v, 6);
        @(negedge clk); chk("R2 wide 16 bits", tx_word, 16'hBEEF);
        wr(A_TXL, 0);
    endtask

    task automatic t_rx();
        logic [31:0] v;
        wr(A_MODE, 32'h40);
        push_rx(16'h0011); push_rx(16'h0022); push_rx(16'h0133);
        rd(A_RXL, v); chk("R4 rx level", v, 3);
        rd(A_RXW, v); chk("R2 rx first", v, 32'h11);
        rd(A_RXW, v); chk("R2 rx second", v, 32'h22);
        rd(A_RXW, v); chk("R2 rx third masked", v, 32'h33);
        rd(A_RXW, v); chk("R12 empty read", v, 0);
        rd(A_RXL, v); chk("R12 level kept", v, 0);
    endtask

    task automatic t_trigger();
        logic [31:0] v;
        wr(A_TRG, 2);
        for (int i = 0; i < 4; i++) push_rx(16'(i));
        idle(2);
        rd(A_STAT, v); chk("R6 gated off", v[0], 0);
        wr(A_RXL, 0);
        wr(A_CTRL, 32'h80000);
        for (int i = 0; i < 3; i++) push_rx(16'(i));
        idle(2);
        rd(A_STAT, v); chk("R6 below threshold", v[0], 0);
        push_rx(16'h9); idle(2);
        rd(A_STAT, v); chk("R6 at threshold 4", v[0], 1);
        wr(A_RXL, 0); wr(A_STAT, 1);
        rd(A_STAT, v); chk("R10 trigger cleared", v, 0);
        wr(A_TRG, 0); push_rx(16'h5); idle(2);
        rd(A_STAT, v); chk("R6 threshold 1", v[0], 1);
        wr(A_RXL, 0); wr(A_STAT, 1); wr(A_CTRL, 0);
    endtask

    task automatic t_overflow_irq();
        logic [31:0] v;
        wr(A_MODE, 32'h40);
        for (int i = 0; i < 33; i++) push_rx(16'(i + 1));
        rd(A_STAT, v); chk("R8 overflow", v, 32'h1000);
        rd(A_RXL, v); chk("R8 level held", v, 32);
        chk("R11 disabled irq", irq, 0);
        wr(A_CTRL, 32'h1000); idle(1);
        chk("R11 enabled irq", irq, 1);
        wr(A_STAT, 32'h1000); idle(1);
        chk("R11 irq after clear", irq, 0);
        rd(A_RXW, v); chk("R8 oldest kept", v, 1);
        wr(A_RXL, 0); wr(A_CTRL, 0);
    endtask

    task automatic t_xend_txtrg();
        logic [31:0] v;
        @(negedge clk); xfer_done = 1; @(negedge clk); xfer_done = 0;
        rd(A_STAT, v); chk("R13 transfer end", v, 32'h100);
        wr(A_STAT, 32'h100);
        wr(A_MODE, 32'h40);
        for (int i = 0; i < 20; i++) wr(A_TXW, i);
        pop_tx();
        rd(A_STAT, v); chk("R13 above half", v[4], 0);
        pop_tx(); pop_tx(); pop_tx();
        rd(A_STAT, v); chk("R13 at half", v[4], 1);
        wr(A_TXL, 0); wr(A_STAT, 32'hFFFF_FFFF);
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        idle(1);
        t_reset();
        t_tx_order();
        t_underrun();
        t_capacity();
        t_rx();
        t_trigger();
        t_overflow_irq();
        t_xend_txtrg();
        done = 1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end
endmodule